// File: doc/BRIEF.md
# Systematic Reed-Solomon Encoder

This block turns a stream of 8-bit message symbols into systematic Reed-Solomon codewords over GF(2^8) that carry 16 check symbols, enough for a decoder to correct up to 8 symbol errors. A source raises `start_i` together with the first message symbol and then supplies one symbol per clock. The encoder forwards each message symbol one cycle later. In parallel, a 16-stage feedback register divides the message by the generator polynomial. Once the last message symbol has passed, the register contents are shifted out as the 16 check symbols.

The message length k is taken from `msg_len_i` when a frame starts. A build-time parameter can instead fix k to a constant. A new frame may start on the cycle right after the last parity cycle, so consecutive codewords can follow each other without gaps.

Top module: `rs_encoder`

## Requirements
- R1: The field is GF(2^8) with reduction polynomial x^8+x^4+x^3+x^2+1 (0x11D), with alpha = 0x02. The output codeword is read as a polynomial whose first symbol on `data_o` is the highest-degree coefficient. This polynomial evaluates to zero at alpha^0 through alpha^15.
- R2: A message symbol presented on `data_i` in a message cycle appears unchanged on `data_o` one clock later.
- R3: Directly after the k message symbols, `data_o` carries exactly 16 check symbols, highest-degree check symbol first. An all-zero message yields 16 zero check symbols.
- R4: `start_o` is high for exactly one cycle per codeword, in the same cycle that the first message symbol is on `data_o`.
- R5: While a frame is in progress (message or parity cycles), the encoder ignores `start_i`. During parity cycles it also ignores `data_i`.
- R6: When PROG_LEN=1, k is the value on `msg_len_i` in the start cycle. A value of 0 is treated as 1, and a value above 239 is treated as 239. When PROG_LEN=0, k is K_FIXED and `msg_len_i` is ignored.
- R7: The parity register clears at each accepted start. A frame that starts on the cycle after the previous frame's last parity cycle is encoded independently of that previous frame.
- R8: After reset, and in every cycle outside a codeword, `data_o` is 0 and `start_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| msg_len_i | input | 8 | Message length k, sampled at start (programmable mode) |
| start_i | input | 1 | Frame start, high with the first message symbol |
| data_i | input | 8 | Message symbol input |
| data_o | output | 8 | Codeword symbol output |
| start_o | output | 1 | High with the first codeword symbol |

## Verification
Codewords are built from several message patterns: all zeros, a ramp, and a scrambled byte sequence. The lengths used are 1, mid-size and the 239-symbol maximum. The scrambled pattern at full length exercises every generator tap together with the field reduction, since its check symbols are judged by evaluating the codeword at all 16 roots. The zero message separates a clean parity register from one left dirty by the previous frame, and the length-one frame probes the boundary where parity starts immediately after the start cycle. Some frames inject stray start pulses and noise on `data_i` during parity, and others run back to back; these show whether framing ignores mid-frame input and whether the register clears between codewords.

// File: rtl/rs_enc_pkg.sv
package rs_enc_pkg;
  localparam int SYM_W = 8;
  localparam int NPAR = 16;
  localparam int N_MAX = (1 << SYM_W) - 1;
  localparam int K_MAX = N_MAX - NPAR;
  localparam logic [SYM_W:0] FIELD_POLY = 9'h11D;

  typedef logic [SYM_W-1:0] sym_t;
  typedef logic [NPAR-1:0][SYM_W-1:0] gen_t;
  typedef enum logic [1:0] {PH_IDLE, PH_MSG, PH_PAR} phase_e;

  function automatic sym_t gf_mul(sym_t a, sym_t b);
    sym_t acc = '0;
    sym_t x = a;
    for (int i = 0; i < SYM_W; i++) begin
      if (b[i]) acc = acc ^ x;
      x = x[SYM_W-1] ? ((x << 1) ^ FIELD_POLY[SYM_W-1:0]) : (x << 1);
    end
    return acc;
  endfunction

  // coefficients 0..NPAR-1 of prod (x + alpha^i), i = 0..NPAR-1 (monic term dropped)
  function automatic gen_t gen_coeffs();
    sym_t g [0:NPAR];
    sym_t root = sym_t'(1);
    gen_t res;
    for (int j = 0; j <= NPAR; j++) g[j] = '0;
    g[0] = sym_t'(1);
    for (int i = 0; i < NPAR; i++) begin
      for (int j = NPAR; j > 0; j--) g[j] = g[j-1] ^ gf_mul(g[j], root);
      g[0] = gf_mul(g[0], root);
      root = gf_mul(root, sym_t'(2));
    end
    for (int j = 0; j < NPAR; j++) res[j] = g[j];
    return res;
  endfunction
endpackage

// File: rtl/rs_enc_lfsr.sv
module rs_enc_lfsr
  import rs_enc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic shift_i,
  input  logic fb_en_i,
  input  sym_t sym_i,
  output sym_t top_o
);
  localparam gen_t GEN = gen_coeffs();

  sym_t stage_q [NPAR];
  sym_t stage_d [NPAR];
  sym_t fb;

  assign fb = fb_en_i ? (sym_i ^ (clear_i ? sym_t'(0) : stage_q[NPAR-1])) : '0;

  for (genvar i = 0; i < NPAR; i++) begin : g_stage
    sym_t prev;
    if (i == 0) begin : g_first
      assign prev = '0;
    end else begin : g_rest
      assign prev = clear_i ? sym_t'(0) : stage_q[i-1];
    end
    assign stage_d[i] = prev ^ gf_mul(fb, GEN[i]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[i] <= '0;
      else if (shift_i || clear_i) stage_q[i] <= stage_d[i];
    end
  end

  assign top_o = stage_q[NPAR-1];

  // parity drain feeds zeros in at the bottom
  assert_drain_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !fb_en_i && !clear_i) |=> (stage_q[0] == '0));

  // a cleared start with a zero symbol leaves an empty register
  assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && fb_en_i && sym_i == '0) |=> (top_o == '0));
endmodule

// File: rtl/rs_enc_ctrl.sv
module rs_enc_ctrl
  import rs_enc_pkg::*;
#(
  parameter bit PROG_LEN = 1'b1,
  parameter int K_FIXED  = K_MAX
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] msg_len_i,
  output logic       accept_o,
  output logic       msg_o,
  output logic       par_o
);
  localparam logic [7:0] KMAX_L = 8'(K_MAX);
  localparam logic [7:0] KFIX_L = 8'(K_FIXED);
  localparam logic [7:0] PLAST  = 8'(NPAR - 1);

  phase_e     phase_q;
  logic [7:0] cnt_q, k_q, k_raw, k_eff;

  assign k_raw = PROG_LEN ? msg_len_i : KFIX_L;
  always_comb begin
    k_eff = k_raw;
    if (k_raw == 8'd0) k_eff = 8'd1;
    else if (k_raw > KMAX_L) k_eff = KMAX_L;
  end

  assign accept_o = start_i && (phase_q == PH_IDLE);
  assign msg_o    = accept_o || (phase_q == PH_MSG);
  assign par_o    = (phase_q == PH_PAR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      k_q     <= 8'd1;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (start_i) begin
          k_q <= k_eff;
          if (k_eff == 8'd1) begin
            phase_q <= PH_PAR;
            cnt_q   <= '0;
          end else begin
            phase_q <= PH_MSG;
            cnt_q   <= 8'd1;
          end
        end
        PH_MSG: if (cnt_q == k_q - 8'd1) begin
          phase_q <= PH_PAR;
          cnt_q   <= '0;
        end else cnt_q <= cnt_q + 8'd1;
        PH_PAR: if (cnt_q == PLAST) begin
          phase_q <= PH_IDLE;
          cnt_q   <= '0;
        end else cnt_q <= cnt_q + 8'd1;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assert_msg_end_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_MSG && cnt_q == k_q - 8'd1) |=> (phase_q == PH_PAR && cnt_q == 8'd0));

  assert_par_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_PAR && cnt_q == PLAST) |=> (phase_q == PH_IDLE));

  assert_busy_ignore_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != PH_IDLE) |=> $stable(k_q));

  assert_len_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (k_q >= 8'd1 && k_q <= KMAX_L));
endmodule

// File: rtl/rs_encoder.sv
module rs_encoder
  import rs_enc_pkg::*;
#(
  parameter bit PROG_LEN = 1'b1,
  parameter int K_FIXED  = rs_enc_pkg::K_MAX
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] msg_len_i,
  input  logic       start_i,
  input  logic [7:0] data_i,
  output logic [7:0] data_o,
  output logic       start_o
);
  logic accept, msg_cyc, par_cyc;
  sym_t par_top, data_q;
  logic start_q;

  rs_enc_ctrl #(.PROG_LEN(PROG_LEN), .K_FIXED(K_FIXED)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .msg_len_i(msg_len_i),
    .accept_o (accept),
    .msg_o    (msg_cyc),
    .par_o    (par_cyc)
  );

  rs_enc_lfsr u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(accept),
    .shift_i(msg_cyc || par_cyc),
    .fb_en_i(msg_cyc),
    .sym_i  (data_i),
    .top_o  (par_top)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= accept;
      if (msg_cyc)      data_q <= data_i;
      else if (par_cyc) data_q <= par_top;
      else              data_q <= '0;
    end
  end

  assign data_o  = data_q;
  assign start_o = start_q;

  assert_start_src_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> $past(start_i));

  assert_passthru_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_cyc |=> (data_o == $past(data_i)));

  assert_idle_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!msg_cyc && !par_cyc) |=> (data_o == '0 && !start_o));
endmodule

// File: tb/rs_encoder_test.sv
module rs_encoder_test;
  localparam int PER = 10;
  localparam int NP = 16;
  localparam int KF = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] msg_len = 8'd0;
  logic       start_p = 1'b0, start_f = 1'b0;
  logic [7:0] data_in = 8'd0;
  logic [7:0] data_o, fdata_o;
  logic       start_o, fstart_o;

  int n_chk = 0, n_bad = 0;
  logic [7:0] msg [0:254];
  logic [7:0] cap [0:254];

  always #(PER/2) clk = ~clk;

  rs_encoder uut (
    .clk_i(clk), .rst_ni(rst_n), .msg_len_i(msg_len), .start_i(start_p),
    .data_i(data_in), .data_o(data_o), .start_o(start_o)
  );

  rs_encoder #(.PROG_LEN(1'b0), .K_FIXED(KF)) uut_fixed (
    .clk_i(clk), .rst_ni(rst_n), .msg_len_i(msg_len), .start_i(start_f),
    .data_i(data_in), .data_o(fdata_o), .start_o(fstart_o)
  );

  function automatic logic [7:0] gmul(logic [7:0] a, logic [7:0] b);
    logic [7:0] r = 8'd0;
    logic [7:0] aa = a;
    logic [7:0] bb = b;
    while (bb != 0) begin
      if (bb[0]) r ^= aa;
      aa = aa[7] ? ((aa << 1) ^ 8'h1D) : (aa << 1);
      bb = bb >> 1;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic fill(input int pat, input int k);
    for (int c = 0; c < k; c++)
      case (pat)
        0: msg[c] = 8'd0;
        1: msg[c] = 8'(c + 1);
        default: msg[c] = 8'((c * 37 + c * c * 11 + pat * 91) ^ (c >> 2));
      endcase
  endtask

  // one codeword; noise adds stray starts and junk data during parity
  task automatic run_frame(input int k, input int len_in, input int pat,
                           input bit fixed, input bit noise, input string tag);
    logic [7:0] root;
    logic [7:0] s;
    bit st;
    fill(pat, k);
    msg_len = 8'(len_in);
    for (int c = 0; c < k + NP; c++) begin
      @(negedge clk);
      st = (c == 0) || (noise && c > 0 && (c == k / 2 || c == k + 5));
      if (fixed) start_f = st; else start_p = st;
      data_in = (c < k) ? msg[c] : (noise ? 8'(8'hC3 ^ c) : 8'd0);
      @(posedge clk);
      #(PER/4);
      cap[c] = fixed ? fdata_o : data_o;
      // R4 start_o only with the first symbol; R5 stray starts ignored
      chk((fixed ? fstart_o : start_o) == (c == 0), {"R4/R5 start_o ", tag},
          int'(fixed ? fstart_o : start_o), int'(c == 0));
    end
    start_p = 1'b0;
    start_f = 1'b0;
    for (int c = 0; c < k; c++)
      chk(cap[c] == msg[c], {"R2 passthrough ", tag}, cap[c], msg[c]);
    if (pat == 0)
      for (int c = k; c < k + NP; c++)
        chk(cap[c] == 8'd0, {"R3 zero parity ", tag}, cap[c], 0);
    root = 8'd1;
    for (int i = 0; i < NP; i++) begin
      s = 8'd0;
      for (int c = 0; c < k + NP; c++) s = gmul(s, root) ^ cap[c];
      chk(s == 8'd0, {"R1 syndrome ", tag}, s, 0);
      root = gmul(root, 8'd2);
    end
  endtask

  task automatic idle_check(input string tag);
    @(negedge clk);
    start_p = 1'b0;
    data_in = 8'h5A;
    @(posedge clk);
    #(PER/4);
    chk(data_o == 8'd0 && !start_o, {"R8 idle ", tag}, int'({start_o, data_o}), 0);
  endtask

  task automatic t_reset();
    #(PER/4);
    chk(data_o == 8'd0 && start_o == 1'b0, "R8 reset", int'({start_o, data_o}), 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_full_length();
    run_frame(239, 239, 5, 1'b0, 1'b0, "k239");
    idle_check("after k239");
  endtask

  task automatic t_zero_then_dirty();
    run_frame(12, 12, 3, 1'b0, 1'b0, "dirty");
    // R7 back-to-back: zero message must give zero parity despite prior state
    run_frame(10, 10, 0, 1'b0, 1'b0, "R7 zero b2b");
    run_frame(33, 33, 1, 1'b0, 1'b0, "R7 ramp b2b");
    idle_check("after b2b");
  endtask

  task automatic t_short();
    run_frame(1, 1, 9, 1'b0, 1'b0, "k1");
    run_frame(1, 0, 4, 1'b0, 1'b0, "R6 len0->1");
    run_frame(2, 2, 7, 1'b0, 1'b0, "k2");
  endtask

  task automatic t_noise();
    run_frame(40, 40, 6, 1'b0, 1'b1, "R5 noise");
    idle_check("after noise");
  endtask

  task automatic t_clamp();
    run_frame(239, 250, 8, 1'b0, 1'b0, "R6 clamp");
  endtask

  task automatic t_fixed();
    run_frame(KF, 5, 2, 1'b1, 1'b0, "R6 fixed");
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_full_length();
    t_zero_then_dirty();
    t_short();
    t_noise();
    t_clamp();
    t_fixed();
    idle_check("end");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule